// File: doc/BRIEF.md
# Byte-Serial Near Relative Call Decoder

This block reads an instruction byte stream one byte at a time. Each byte arrives with the address it was fetched from, over a valid/ready handshake. The block skips any number of prefix bytes and recognises the near relative call opcode 0xE8. It then gathers a 16-bit or 32-bit displacement and reports a call event. The event carries two values. The return address is the address just past the last displacement byte. The branch target is that return address plus the sign-extended displacement. Any other opcode gives a one-cycle not-call pulse, and the decoder goes back to scanning.

The decoder never records where an instruction began. It keeps a running pointer to the next byte and the address of the most recent prefix byte. An interrupt request is taken at any point outside displacement collection. On acceptance the block reports a resume address. If prefixes are pending, that address is the final prefix byte and not the first one, so earlier prefixes are lost on return. The `mode32` input selects the default displacement width and the address wrap width.

Top module: `rel_call_decoder`

## Requirements
- R1: After synchronous reset the following hold: `call_valid`, `not_call` and `irq_ack` are 0, `resume_addr` is 0, the running pointer is 0, no prefix is pending, and `in_ready` is 1 while `irq_req` is 0.
- R2: With `mode32`=1 and no operand-size prefix, byte 0xE8 is followed by four displacement bytes, least significant first. One cycle after the fourth byte is accepted, `call_valid` pulses for exactly one cycle. On that pulse, `call_return` is the fourth byte's address + 1 and `call_target` is `call_return` plus the displacement, read as a signed value.
- R3: With `mode32`=0, 0xE8 takes two displacement bytes, least significant first. The 16-bit displacement is sign-extended. `call_target` and `call_return` wrap modulo 2^16, so their upper bits are 0.
- R4: The prefix byte 0x66 flips the displacement width away from the `mode32` default: 2 bytes become 4, and 4 bytes become 2. Several 0x66 bytes before one opcode flip it only once.
- R5: The prefix bytes 0x26, 0x2E, 0x36, 0x3E, 0xF2 and 0xF3 are consumed without any output pulse, and they do not change the displacement width.
- R6: Any accepted byte that is neither a prefix nor 0xE8 causes a one-cycle `not_call` pulse on the next cycle. It also drops all pending prefix state, including the width flip.
- R7: When `irq_req` is 1 and the decoder is not collecting displacement bytes, the request is accepted. One cycle later `irq_ack` pulses and `resume_addr` is updated. `resume_addr` is the address of the most recent prefix byte if prefixes are pending, and otherwise the running next-byte pointer. Pending prefix state is dropped.
- R8: An interrupt request is not accepted while displacement bytes are being collected. In that state `in_ready` stays 1. A request still held when the call completes is accepted in the following cycle.
- R9: A byte is consumed only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly while an interrupt is being accepted. Idle gaps in `in_valid` do not disturb a partly decoded instruction.
- R10: With `mode32`=1, `call_target` and `call_return` wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32 | input | 1 | 1: 32-bit default width and 2^32 wrap; 0: 16-bit width and 2^16 wrap |
| in_valid | input | 1 | Instruction byte present |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_byte | input | 8 | Instruction byte |
| in_addr | input | 32 | Fetch address of `in_byte` |
| irq_req | input | 1 | Interrupt request |
| call_valid | output | 1 | One-cycle call event |
| call_target | output | 32 | Branch target of the call event |
| call_return | output | 32 | Return address to push |
| not_call | output | 1 | One-cycle flag for a non-call opcode |
| irq_ack | output | 1 | One-cycle interrupt acceptance pulse |
| resume_addr | output | 32 | Resume address reported with the last `irq_ack` |

## Verification
A wrong byte count or a stuck width flag shows up at the ports right away. The `call_valid` pulse comes a cycle early or late against the byte stream, or a `not_call` pulse appears on a displacement byte. A wrong shift order or a wrong sign extension is caught on the very pulse where `call_target` is compared. Prefix state that is cleared too early or too late moves `resume_addr` on the next `irq_ack`, or changes the width of the next call. The bench therefore predicts every output on every clock and does not wait for final results.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [0:0] {
    ST_SCAN = 1'b0,
    ST_DISP = 1'b1
  } rcd_state_e;

  localparam logic [7:0] OPC_NEAR_CALL = 8'hE8;
  localparam logic [7:0] PFX_OPSIZE    = 8'h66;
endpackage

// File: rtl/rcd_classify.sv
module rcd_classify #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] byte_in,
  output logic          is_call,
  output logic          is_opsize,
  output logic          is_other_pfx
);
  import rcd_pkg::*;

  localparam int NPFX = 6;
  localparam logic [NPFX*BW-1:0] PFX_LIST = {8'h26, 8'h2E, 8'h36, 8'h3E, 8'hF2, 8'hF3};

  logic [NPFX-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NPFX; g++) begin : g_pfx
      assign hit[g] = (byte_in == PFX_LIST[g*BW +: BW]);
    end
  endgenerate

  always_comb begin
    is_call      = (byte_in == OPC_NEAR_CALL);
    is_opsize    = (byte_in == PFX_OPSIZE);
    is_other_pfx = |hit;
  end
endmodule

// File: rtl/rcd_disp_collect.sv
module rcd_disp_collect #(
  parameter int AW     = 32,
  parameter int BW     = 8,
  parameter int NARROW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load,
  input  logic          wide,
  input  logic [BW-1:0] byte_in,
  output logic          last,
  output logic [AW-1:0] disp_sext
);
  localparam int WIDE_B   = AW / BW;
  localparam int NARROW_B = NARROW / BW;
  localparam int CW       = $clog2(WIDE_B + 1);

  logic [AW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic [AW-1:0] merged;

  always_comb begin
    need   = wide ? CW'(WIDE_B) : CW'(NARROW_B);
    last   = load && (cnt_q == need - CW'(1));
    merged = {byte_in, sh_q[AW-1:BW]};
    if (wide) disp_sext = merged;
    else      disp_sext = {{(AW-NARROW){merged[AW-1]}}, merged[AW-1 -: NARROW]};
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= merged;
      cnt_q <= last ? '0 : cnt_q + CW'(1);
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(WIDE_B));
endmodule

// File: rtl/rcd_addr_calc.sv
module rcd_addr_calc #(
  parameter int AW     = 32,
  parameter int NARROW = 16
) (
  input  logic          mode32,
  input  logic [AW-1:0] byte_addr,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] end_addr,
  output logic [AW-1:0] target
);
  localparam logic [AW-1:0] MASK_N = {{(AW-NARROW){1'b0}}, {NARROW{1'b1}}};

  logic [AW-1:0] mask;

  always_comb begin
    mask     = mode32 ? '1 : MASK_N;
    end_addr = (byte_addr + AW'(1)) & mask;
    target   = (end_addr + disp) & mask;
  end
endmodule

// File: rtl/rel_call_decoder.sv
module rel_call_decoder #(
  parameter int AW     = 32,
  parameter int BW     = 8,
  parameter int NARROW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode32,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_byte,
  input  logic [AW-1:0] in_addr,
  input  logic          irq_req,
  output logic          call_valid,
  output logic [AW-1:0] call_target,
  output logic [AW-1:0] call_return,
  output logic          not_call,
  output logic          irq_ack,
  output logic [AW-1:0] resume_addr
);
  import rcd_pkg::*;

  rcd_state_e    state_q;
  logic          pfx_q, opsz_q, wide_q;
  logic [AW-1:0] next_ptr_q, last_pfx_q;

  logic is_call, is_opsize, is_other_pfx;
  logic take_irq, take_byte, in_disp;
  logic start_disp, disp_last;
  logic [AW-1:0] disp_sext, end_addr, target;

  rcd_classify #(.BW(BW)) u_class (
    .byte_in(in_byte), .is_call(is_call), .is_opsize(is_opsize),
    .is_other_pfx(is_other_pfx)
  );

  always_comb begin
    in_disp    = (state_q == ST_DISP);
    take_irq   = irq_req && !in_disp;
    in_ready   = !take_irq;
    take_byte  = in_valid && in_ready;
    start_disp = take_byte && !in_disp && is_call;
  end

  rcd_disp_collect #(.AW(AW), .BW(BW), .NARROW(NARROW)) u_disp (
    .clk(clk), .rst(rst), .start(start_disp), .load(take_byte && in_disp),
    .wide(wide_q), .byte_in(in_byte), .last(disp_last), .disp_sext(disp_sext)
  );

  rcd_addr_calc #(.AW(AW), .NARROW(NARROW)) u_addr (
    .mode32(mode32), .byte_addr(in_addr), .disp(disp_sext),
    .end_addr(end_addr), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SCAN;
      pfx_q       <= 1'b0;
      opsz_q      <= 1'b0;
      wide_q      <= 1'b0;
      next_ptr_q  <= '0;
      last_pfx_q  <= '0;
      call_valid  <= 1'b0;
      call_target <= '0;
      call_return <= '0;
      not_call    <= 1'b0;
      irq_ack     <= 1'b0;
      resume_addr <= '0;
    end else begin
      call_valid <= 1'b0;
      not_call   <= 1'b0;
      irq_ack    <= 1'b0;
      if (take_irq) begin
        irq_ack     <= 1'b1;
        resume_addr <= pfx_q ? last_pfx_q : next_ptr_q;
        pfx_q       <= 1'b0;
        opsz_q      <= 1'b0;
      end else if (take_byte) begin
        next_ptr_q <= end_addr;
        if (in_disp) begin
          if (disp_last) begin
            call_valid  <= 1'b1;
            call_target <= target;
            call_return <= end_addr;
            state_q     <= ST_SCAN;
            pfx_q       <= 1'b0;
            opsz_q      <= 1'b0;
          end
        end else if (is_opsize || is_other_pfx) begin
          pfx_q      <= 1'b1;
          last_pfx_q <= in_addr;
          if (is_opsize) opsz_q <= 1'b1;
        end else if (is_call) begin
          state_q <= ST_DISP;
          wide_q  <= mode32 ^ opsz_q;
        end else begin
          not_call <= 1'b1;
          pfx_q    <= 1'b0;
          opsz_q   <= 1'b0;
        end
      end
    end
  end

  assert_call_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    call_valid |=> !call_valid);
  assert_one_event_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({call_valid, not_call, irq_ack}));
  assert_wrap16_R3: assert property (@(posedge clk) disable iff (rst)
    (take_byte && disp_last && !mode32) |=> (call_target[AW-1:NARROW] == '0));
  assert_irq_clears_R7: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (!pfx_q && !opsz_q && state_q == ST_SCAN));
  assert_no_irq_in_disp_R8: assert property (@(posedge clk) disable iff (rst)
    in_disp |-> in_ready);
endmodule

// File: tb/test_rel_call_decoder.sv
module test_rel_call_decoder;
  logic        clk = 0, rst = 1, mode32 = 1, in_valid = 0, irq_req = 0;
  logic [7:0]  in_byte = 0;
  logic [31:0] in_addr = 0;
  logic        in_ready, call_valid, not_call, irq_ack;
  logic [31:0] call_target, call_return, resume_addr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rel_call_decoder i_rel_call_decoder (
    .clk(clk), .rst(rst), .mode32(mode32), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_addr(in_addr), .irq_req(irq_req), .call_valid(call_valid),
    .call_target(call_target), .call_return(call_return), .not_call(not_call),
    .irq_ack(irq_ack), .resume_addr(resume_addr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_pfx, m_opsz, m_disp;
  int          m_cnt, m_need;
  logic [31:0] m_val, m_next, m_lastpfx, m_res, m_tgt, m_ret;
  bit          e_cv, e_nc, e_ack, e_rdy, model_on = 0;

  always @(posedge clk) begin
    logic [31:0] mask, e;
    mask  = mode32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    e_rdy = !(irq_req && !m_disp);
    e_cv = 0; e_nc = 0; e_ack = 0;
    if (rst) begin
      m_pfx = 0; m_opsz = 0; m_disp = 0; m_next = 0; m_lastpfx = 0; m_res = 0;
      m_tgt = 0; m_ret = 0;
    end else if (irq_req && !m_disp) begin
      e_ack = 1; m_res = m_pfx ? m_lastpfx : m_next; m_pfx = 0; m_opsz = 0;
    end else if (in_valid) begin
      e = (in_addr + 1) & mask;
      m_next = e;
      if (m_disp) begin
        m_val = m_val | (32'(in_byte) << (8 * m_cnt));
        m_cnt++;
        if (m_cnt == m_need) begin
          if (m_need == 2) m_val = {{16{m_val[15]}}, m_val[15:0]};
          m_ret = e; m_tgt = (e + m_val) & mask;
          e_cv = 1; m_disp = 0; m_pfx = 0; m_opsz = 0;
        end
      end else if (in_byte == 8'h66) begin
        m_pfx = 1; m_opsz = 1; m_lastpfx = in_addr;
      end else if (in_byte inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'hF2, 8'hF3}) begin
        m_pfx = 1; m_lastpfx = in_addr;
      end else if (in_byte == 8'hE8) begin
        m_disp = 1; m_cnt = 0; m_val = 0; m_need = (mode32 ^ m_opsz) ? 4 : 2;
      end else begin
        e_nc = 1; m_pfx = 0; m_opsz = 0;
      end
    end
    if (model_on) begin
      chk("R9 in_ready", 32'(in_ready), 32'(e_rdy));
      #5;
      chk("R2 call_valid", 32'(call_valid), 32'(e_cv));
      chk("R6 not_call", 32'(not_call), 32'(e_nc));
      chk("R7 irq_ack", 32'(irq_ack), 32'(e_ack));
      chk("R7 resume_addr", resume_addr, m_res);
      if (e_cv) begin
        chk("R2 call_target", call_target, m_tgt);
        chk("R2 call_return", call_return, m_ret);
      end
    end
  end

  task automatic put(logic [31:0] a, logic [7:0] b);
    @(negedge clk); in_valid = 1; in_addr = a; in_byte = b;
  endtask
  task automatic idle();
    @(negedge clk); in_valid = 0; #1;
  endtask
  task automatic call_seq(logic [31:0] a, int n, logic [31:0] d);
    put(a, 8'hE8);
    for (int i = 0; i < n; i++) put(a + 1 + i, d[8*i +: 8]);
    idle();
  endtask
  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; model_on = 1; #1;
    chk("R1 call_valid", 32'(call_valid), 0);
    chk("R1 not_call", 32'(not_call), 0);
    chk("R1 irq_ack", 32'(irq_ack), 0);
    chk("R1 resume", resume_addr, 0);
    chk("R1 in_ready", 32'(in_ready), 1);

    mode32 = 1;
    call_seq(32'h1000, 4, 32'h0000_0010);
    chk("R2 target pos", call_target, 32'h1015); chk("R2 return", call_return, 32'h1005);
    call_seq(32'h2000, 4, 32'hFFFF_FFFE);
    chk("R2 target neg", call_target, 32'h2003);

    mode32 = 0;
    call_seq(32'hFFF0, 2, 32'h0020);
    chk("R3 wrap target", call_target, 32'h0013); chk("R3 return", call_return, 32'hFFF3);
    call_seq(32'h0100, 2, 32'hFF00);
    chk("R3 neg target", call_target, 32'h0003);

    put(32'h200, 8'h66);
    call_seq(32'h201, 4, 32'h0000_0100);
    chk("R4 widen target", call_target, 32'h0306);

    mode32 = 1;
    put(32'h300, 8'h66); put(32'h301, 8'h66);
    call_seq(32'h302, 2, 32'h0004);
    chk("R4 narrow target", call_target, 32'h0309);

    put(32'h400, 8'h2E); put(32'h401, 8'hF3); put(32'h402, 8'h26);
    put(32'h403, 8'h36); put(32'h404, 8'h3E); put(32'h405, 8'hF2);
    call_seq(32'h406, 4, 32'h0000_0008);
    chk("R5 other prefixes", call_target, 32'h0413);

    put(32'h500, 8'h66); put(32'h501, 8'h90); idle();
    chk("R6 not_call pulse", 32'(not_call), 1);
    call_seq(32'h502, 4, 32'h0000_0001);
    chk("R6 prefix dropped", call_target, 32'h0508);

    put(32'h600, 8'h2E); put(32'h601, 8'hF3);
    @(negedge clk); in_valid = 0; irq_req = 1;
    @(negedge clk); irq_req = 0; #1;
    chk("R7 last prefix", resume_addr, 32'h601); chk("R7 ack", 32'(irq_ack), 1);
    @(negedge clk); irq_req = 1;
    @(negedge clk); irq_req = 0; #1;
    chk("R7 next pointer", resume_addr, 32'h602);
    put(32'h700, 8'h66);
    @(negedge clk); in_valid = 0; irq_req = 1;
    @(negedge clk); irq_req = 0; #1;
    chk("R7 resume prefix", resume_addr, 32'h700);
    call_seq(32'h701, 4, 32'h0);
    chk("R7 width reset", call_target, 32'h0706);

    put(32'h800, 8'hE8); put(32'h801, 8'h05);
    irq_req = 1; #1;
    chk("R8 ready in disp", 32'(in_ready), 1);
    put(32'h802, 8'h00); put(32'h803, 8'h00); put(32'h804, 8'h00);
    @(negedge clk); in_valid = 0; #1;
    chk("R8 call first", 32'(call_valid), 1); chk("R8 ready low", 32'(in_ready), 0);
    @(negedge clk); irq_req = 0; #1;
    chk("R8 deferred ack", 32'(irq_ack), 1); chk("R8 resume", resume_addr, 32'h805);
    chk("R8 target", call_target, 32'h080A);

    irq_req = 1; in_valid = 1; in_addr = 32'h900; in_byte = 8'hE8; #1;
    chk("R9 ready blocked", 32'(in_ready), 0);
    @(negedge clk); irq_req = 0;
    @(negedge clk); in_valid = 0;
    @(negedge clk); put(32'h901, 8'h03);
    @(negedge clk); in_valid = 0;
    put(32'h902, 8'h00); idle(); idle();
    put(32'h903, 8'h00); put(32'h904, 8'h00); idle();
    chk("R9 gapped target", call_target, 32'h0908);

    call_seq(32'hFFFF_FFF0, 4, 32'h0000_0020);
    chk("R10 wrap target", call_target, 32'h0000_0015);
    chk("R10 return", call_return, 32'hFFFF_FFF5);

    rst = 1; idle(); rst = 0; #1;
    chk("R1 reset resume", resume_addr, 0);
    idle();
    finish_run();
  end
endmodule